// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Recognition

This block turns an asynchronous serial line into characters. A free-running enable pulses sixteen times per bit period and paces all sampling. The line is first passed through a two-stage synchronizer. A falling edge is accepted as a start bit only if the line is still low half a bit later. Every later bit is sampled at its centre. The character format comes from a set of static configuration inputs: the data width (five to eight bits), the parity mode, and a nine-bit mode in which an extra ninth bit replaces parity.

Each finished character appears for exactly one clock as a data word with three tags. The parity tag carries the parity result, or the ninth bit in nine-bit mode. The framing tag marks a low stop sample. The break tag marks a line that stayed low for a whole character. These outputs feed a receive queue that lies outside the block.

Two recovery behaviours set this receiver apart. After a framing error, the low stop sample is taken as the start bit of the next character, and reception goes straight on with its data bits. After a break, a single all-zero character is delivered, and the receiver then ignores the line until it returns high.

Top module: `serial_char_rx`

## Requirements
- R1: While reset is held and after its release with the line idle high, charValid is 0 and charData, parityTag, frameTag and breakTag are all 0.
- R2: A low level that has gone high again by the half-bit point (8 of 16 ticks after it was seen) is rejected and produces no character.
- R3: Data bits are received least significant bit first. wordLen selects the width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of charData above the configured width read 0.
- R4: When parityMode[0] is 0 there is no parity bit. When it is 1, parityMode[2:1] selects the expected bit: 00 odd, 01 even, 10 a constant 1, 11 a constant 0. A received parity bit that differs from the expected one sets parityTag.
- R5: When nineBit is 1, wordLen and parityMode are ignored. Eight data bits are received, then a ninth bit, and the ninth bit is reported on parityTag.
- R6: A character whose stop-bit sample is low, and which is not a break, is delivered with frameTag set.
- R7: After a framing error, the low stop sample counts as the start bit of the next character. The next bit period is received as that character's bit 0.
- R8: If the start bit, every data bit, the parity or ninth bit, and the stop sample are all low, exactly one character is delivered. It has charData equal to 0, breakTag 1, frameTag 0 and parityTag 0.
- R9: After a break, the line being held low produces no further characters. Once the line returns high, normal reception resumes.
- R10: charValid is high for exactly one clock per character. Only the first stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 pulses per bit period |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| wordLen | input | 2 | Data width select (00=5 to 11=8 bits) |
| parityMode | input | 3 | Bit 0 enables parity; bits 2:1 select odd, even, forced 1 or forced 0 |
| nineBit | input | 1 | Nine-bit framing mode |
| charValid | output | 1 | One-clock strobe marking a delivered character |
| charData | output | 8 | Received data word, right aligned |
| parityTag | output | 1 | Parity mismatch, or the ninth bit in nine-bit mode |
| frameTag | output | 1 | Stop sample was low (not a break) |
| breakTag | output | 1 | Character was a break |

## Verification
The assertions assume three things about the inputs. The configuration inputs stay constant while a character is being received. sampleTick pulses at most once per clock. Each character spans many clocks, so two delivery strobes can never fall on adjacent cycles. The bench keeps to these assumptions. It changes the configuration only while the line is idle, drives sampleTick every second clock, and holds each serial bit for 32 clocks, so every centre sample lands well inside its bit. The random frames draw the width, parity mode, nine-bit mode, data and a deliberate parity flip. Directed cases then add a short glitch, a framing error followed by a resynchronized character, and long-held and minimum-length breaks.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef struct packed {
    logic clearWord;
    logic takeData;
    logic takeExtra;
    logic finish;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxBit,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             nineBit,
  input  logic             lineZero,
  output rxStrobe_t        stb,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int CNTW = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_EXTRA, S_STOP, S_WAITHI} rxState_t;

  rxState_t state, stateNxt;
  logic [CNTW-1:0] cnt, cntNxt;
  logic [IDX_W-1:0] idxNxt, lastIdx;
  logic atCentre;

  assign lastIdx  = nineBit ? IDX_W'(DATA_W - 1) : IDX_W'(4) + IDX_W'(wordLen);
  assign atCentre = sampleTick && (cnt == CNTW'(OVS - 1));

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    idxNxt   = bitIdx;
    stb      = '0;
    unique case (state)
      S_IDLE: begin
        if (sampleTick && !rxBit) begin
          stateNxt = S_START;
          cntNxt   = '0;
        end
      end
      S_START: begin
        if (sampleTick) begin
          if (cnt == CNTW'(HALF - 1)) begin
            cntNxt = '0;
            if (!rxBit) begin
              stateNxt      = S_DATA;
              idxNxt        = '0;
              stb.clearWord = 1'b1;
            end else begin
              stateNxt = S_IDLE;
            end
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
      end
      S_DATA, S_EXTRA, S_STOP: begin
        if (sampleTick) cntNxt = atCentre ? '0 : cnt + 1'b1;
        if (atCentre) begin
          if (state == S_DATA) begin
            stb.takeData = 1'b1;
            if (bitIdx == lastIdx) stateNxt = (nineBit || parityEn) ? S_EXTRA : S_STOP;
            else idxNxt = bitIdx + 1'b1;
          end else if (state == S_EXTRA) begin
            stb.takeExtra = 1'b1;
            stateNxt      = S_STOP;
          end else begin
            stb.finish = 1'b1;
            if (rxBit) stateNxt = S_IDLE;
            else if (lineZero) stateNxt = S_WAITHI;
            else begin
              stateNxt      = S_DATA;
              idxNxt        = '0;
              stb.clearWord = 1'b1;
            end
          end
        end
      end
      S_WAITHI: begin
        if (rxBit) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      bitIdx <= idxNxt;
    end
  end

  // R2
  start_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_START && sampleTick && cnt == CNTW'(HALF - 1) && rxBit) |=> (state == S_IDLE));

  // R7
  resync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && atCentre && !rxBit && !lineZero) |=> (state == S_DATA && bitIdx == '0 && cnt == '0));

  // R8
  brk_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && atCentre && !rxBit && lineZero) |=> (state == S_WAITHI));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITHI && !rxBit) |=> (state == S_WAITHI && !stb.finish));
endmodule

// File: rtl/serial_rx_data.sv
module serial_rx_data
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  rxStrobe_t         stb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              nineBit,
  input  logic [2:0]        parityMode,
  output logic              rxBit,
  output logic              lineZero,
  output logic              charValid,
  output logic [DATA_W-1:0] charData,
  output logic              parityTag,
  output logic              frameTag,
  output logic              breakTag
);
  logic [1:0] syncQ;
  logic [DATA_W-1:0] wordQ;
  logic extraQ, allZeroQ;
  logic expBit, parityErr, isBreak;

  assign rxBit    = syncQ[1];
  assign lineZero = allZeroQ;

  always_comb begin
    unique case (parityMode[2:1])
      2'b00:   expBit = ~(^wordQ);
      2'b01:   expBit = ^wordQ;
      2'b10:   expBit = 1'b1;
      default: expBit = 1'b0;
    endcase
  end

  assign parityErr = !nineBit && parityMode[0] && (extraQ != expBit);
  assign isBreak   = !rxBit && allZeroQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      wordQ    <= '0;
      extraQ   <= 1'b0;
      allZeroQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], serialIn};
      if (stb.clearWord) begin
        wordQ    <= '0;
        extraQ   <= 1'b0;
        allZeroQ <= 1'b1;
      end else if (stb.takeData) begin
        wordQ[bitIdx] <= rxBit;
        if (rxBit) allZeroQ <= 1'b0;
      end else if (stb.takeExtra) begin
        extraQ <= rxBit;
        if (rxBit) allZeroQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charValid <= 1'b0;
      charData  <= '0;
      parityTag <= 1'b0;
      frameTag  <= 1'b0;
      breakTag  <= 1'b0;
    end else begin
      charValid <= stb.finish;
      if (stb.finish) begin
        charData  <= wordQ;
        breakTag  <= isBreak;
        frameTag  <= !rxBit && !allZeroQ;
        parityTag <= nineBit ? extraQ : (!isBreak && parityErr);
      end
    end
  end

  // R8
  brk_char_chk: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && breakTag) |-> (charData == '0 && !frameTag && !parityTag));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> !charValid);
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              serialIn,
  input  logic [1:0]        wordLen,
  input  logic [2:0]        parityMode,
  input  logic              nineBit,
  output logic              charValid,
  output logic [DATA_W-1:0] charData,
  output logic              parityTag,
  output logic              frameTag,
  output logic              breakTag
);
  rxStrobe_t stb;
  logic [IDX_W-1:0] bitIdx;
  logic rxBit, lineZero;

  serial_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxBit(rxBit),
    .wordLen(wordLen), .parityEn(parityMode[0]), .nineBit(nineBit),
    .lineZero(lineZero), .stb(stb), .bitIdx(bitIdx)
  );

  serial_rx_data u_data (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .stb(stb), .bitIdx(bitIdx),
    .nineBit(nineBit), .parityMode(parityMode), .rxBit(rxBit), .lineZero(lineZero),
    .charValid(charValid), .charData(charData), .parityTag(parityTag),
    .frameTag(frameTag), .breakTag(breakTag)
  );
endmodule

// File: tb/serial_char_rx_tb.sv
module serial_char_rx_tb;
  localparam int BIT_CYC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickPh = 1'b0;
  logic serialIn = 1'b1;
  logic [1:0] wordLen = 2'b11;
  logic [2:0] parityMode = 3'b000;
  logic nineBit = 1'b0;
  logic charValid;
  logic [7:0] charData;
  logic parityTag, frameTag, breakTag;

  int checks = 0;
  int errors = 0;
  int gotN = 0;
  int pulseErr = 0;
  logic prevValid = 1'b0;
  logic [7:0] logD [256];
  logic logP [256];
  logic logF [256];
  logic logB [256];

  always #4 clk = ~clk;
  always @(posedge clk) tickPh <= ~tickPh;

  serial_char_rx u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(tickPh), .serialIn(serialIn),
    .wordLen(wordLen), .parityMode(parityMode), .nineBit(nineBit),
    .charValid(charValid), .charData(charData), .parityTag(parityTag),
    .frameTag(frameTag), .breakTag(breakTag)
  );

  always @(negedge clk) begin
    if (charValid && prevValid) pulseErr++;
    prevValid = charValid;
    if (charValid) begin
      if (gotN < 256) begin
        logD[gotN] = charData;
        logP[gotN] = parityTag;
        logF[gotN] = frameTag;
        logB[gotN] = breakTag;
      end
      gotN++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input logic [1:0] wl);
    return d & 8'((9'd1 << (5 + wl)) - 1);
  endfunction

  function automatic logic parBit(input logic [7:0] d, input logic [2:0] pm);
    case (pm[2:1])
      2'b00:   return ~(^d);
      2'b01:   return ^d;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk) serialIn = b;
    repeat (BIT_CYC - 1) @(negedge clk);
  endtask

  task automatic sendBody(input logic [7:0] d, input logic ninth, input logic flip, input logic stopVal);
    int n;
    logic [7:0] md;
    n  = nineBit ? 8 : 5 + int'(wordLen);
    md = nineBit ? d : maskData(d, wordLen);
    for (int i = 0; i < n; i++) sendBit(md[i]);
    if (nineBit) sendBit(ninth);
    else if (parityMode[0]) sendBit(parBit(md, parityMode) ^ flip);
    sendBit(stopVal);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic ninth, input logic flip);
    sendBit(1'b0);
    sendBody(d, ninth, flip, 1'b1);
    sendBit(1'b1);
  endtask

  initial begin
    int n0;
    logic [7:0] d;
    logic ninth, flip;
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", int'(charValid), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 valid idle", int'(charValid), 0);
    chk("R1 outputs idle", int'({charData, parityTag, frameTag, breakTag}), 0);

    // R2 glitch of 5 ticks
    n0 = gotN;
    @(negedge clk) serialIn = 1'b0;
    repeat (10) @(negedge clk);
    serialIn = 1'b1;
    repeat (4 * BIT_CYC) @(negedge clk);
    chk("R2 glitch rejected", gotN, n0);

    // R3 directed: 8-bit even parity
    wordLen = 2'b11; parityMode = 3'b011; nineBit = 1'b0;
    n0 = gotN;
    sendChar(8'hA5, 1'b0, 1'b0);
    chk("R3 count", gotN, n0 + 1);
    chk("R3 data A5", int'(logD[n0]), 'hA5);
    chk("R4 even ok", int'(logP[n0]), 0);

    // R5 nine-bit with ninth bit 1, config fields ignored
    wordLen = 2'b00; parityMode = 3'b001; nineBit = 1'b1;
    n0 = gotN;
    sendChar(8'hC3, 1'b1, 1'b0);
    chk("R5 data", int'(logD[n0]), 'hC3);
    chk("R5 ninth on parityTag", int'(logP[n0]), 1);
    nineBit = 1'b0;

    // R3 R4 R5 R6 R10 random frames
    for (int k = 0; k < 40; k++) begin
      wordLen    = 2'($urandom % 4);
      parityMode = 3'($urandom % 8);
      nineBit    = ($urandom % 4) == 0;
      d          = 8'($urandom);
      ninth      = 1'($urandom % 2);
      flip       = ($urandom % 3) == 0;
      n0 = gotN;
      sendChar(d, ninth, flip);
      chk("R10 one char", gotN, n0 + 1);
      chk("R3 data", int'(logD[n0]), int'(nineBit ? d : maskData(d, wordLen)));
      chk("R4 parity tag", int'(logP[n0]), int'(nineBit ? ninth : (parityMode[0] & flip)));
      chk("R6 no frame", int'(logF[n0]), 0);
      chk("R8 no break", int'(logB[n0]), 0);
    end
    nineBit = 1'b0;

    // R6 R7 framing error then resync
    wordLen = 2'b11; parityMode = 3'b000;
    n0 = gotN;
    sendBit(1'b0);
    sendBody(8'h3C, 1'b0, 1'b0, 1'b0);
    sendBody(8'h96, 1'b0, 1'b0, 1'b1);
    sendBit(1'b1);
    chk("R7 two chars", gotN, n0 + 2);
    chk("R6 frame tag", int'(logF[n0]), 1);
    chk("R6 data kept", int'(logD[n0]), 'h3C);
    chk("R7 resync data", int'(logD[n0 + 1]), 'h96);
    chk("R7 resync no frame", int'(logF[n0 + 1]), 0);

    // R8 R9 long break, 8-bit odd parity
    parityMode = 3'b001;
    n0 = gotN;
    for (int i = 0; i < 30; i++) sendBit(1'b0);
    chk("R9 one char while low", gotN, n0 + 1);
    sendBit(1'b1); sendBit(1'b1);
    chk("R9 one char total", gotN, n0 + 1);
    chk("R8 break tag", int'(logB[n0]), 1);
    chk("R8 break data", int'(logD[n0]), 0);
    chk("R8 break no frame", int'(logF[n0]), 0);
    chk("R8 break no parity", int'(logP[n0]), 0);
    n0 = gotN;
    sendChar(8'h5A, 1'b0, 1'b0);
    chk("R9 recover data", int'(logD[n0]), 'h5A);

    // R8 minimum break, 5-bit no parity
    wordLen = 2'b00; parityMode = 3'b000;
    n0 = gotN;
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    sendBit(1'b1); sendBit(1'b1);
    chk("R8 short break count", gotN, n0 + 1);
    chk("R8 short break tag", int'(logB[n0]), 1);

    chk("R10 pulse width", pulseErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule